// File: doc/BRIEF.md
# Multi-input RMS power accumulator

The block gathers level statistics for a set of parallel signed sample streams. A single pulse on the control strobe arms one measurement run. For each input lane it then adds up the next 2^LOG2_WIN accepted samples, and it adds up their squares as well. With the default parameters that is eight lanes of 8-bit samples over a 65536-sample window. The 24-bit sum and the 32-bit sum of squares are enough to work out the mean and the RMS level of each lane. The block leaves the square root to whoever reads the results.

When a run ends, every lane's two totals go into a word-addressed result memory in one clock edge. The sum of lane i sits at word 2i and its sum of squares at word 2i+1. A done flag then stays up until the next control write. A reader can poll the memory at any time. A run that is still in progress never changes the words it will later replace. The block does not run freely: with no control write, nothing accumulates.

Top module: `rms_power_accum`

## Requirements
- R1: After reset, busy and done are both 0 and every result word reads 0.
- R2: A control write sets busy to 1 and done to 0 from the next clock edge.
- R3: A run takes exactly 2^LOG2_WIN samples, counted only on cycles with busy=1 and samp_valid=1. A sample offered while idle, or with samp_valid=0, has no effect on any result.
- R4: Word 2i holds the two's complement sum of lane i's samples. The sum fills bits [SUM_W-1:0] and the bits above it are 0. With the defaults the sign sits at bit 23.
- R5: Word 2i+1 holds the unsigned sum of the squared samples of lane i, SQ_W bits wide.
- R6: The result memory changes only when a run ends. Reads taken during a later run return the previous results, and done stays 1 until the next control write.
- R7: A control write during a run restarts the run from zero. A sample presented in the same cycle as the control write is not counted.
- R8: rd_data shows the word that rd_addr selected at the previous clock edge (one cycle of read latency).
- R9: Lane i takes its sample from bits [i*SAMP_W +: SAMP_W] of samp_data. Each lane accumulates independently of the others.
- R10: busy falls on the edge that accepts the final sample. The result memory and done are updated together one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe; starts or restarts a run |
| samp_valid | input | 1 | Qualifies samp_data in this cycle |
| samp_data | input | N_IN*SAMP_W | Packed samples, lane 0 in the low bits |
| busy | output | 1 | A run is collecting samples |
| done | output | 1 | Results of a finished run are in the memory |
| rd_addr | input | $clog2(2*N_IN) | Result word address |
| rd_data | output | max(SUM_W,SQ_W) | Registered result word |

## Verification
The bench keeps the default lane count, sample width and result widths. It shrinks LOG2_WIN to 4, so each run covers 16 samples and many complete runs fit in a short simulation. The short window brings these cases within reach: extreme codes held for a full run (all -128, all 127, -1), runs with gaps in samp_valid, a restart in the middle of a run, and reads of old results while a new run is under way. Only the sample counter is narrower than it would be with the default window; the arithmetic widths stay the same.

// File: rtl/rms_acc_pkg.sv
// Package rms_acc_pkg
// Shared types for the RMS power accumulator: the control bundle that the
// run sequencer drives into every lane accumulator.
package rms_acc_pkg;

    // Per-cycle control issued by the sequencer to all lanes.
    typedef struct packed {
        logic clr;     // zero the running totals
        logic en;      // add the current sample
        logic commit;  // copy the totals into the result memory
    } acc_ctl_t;

endpackage

// File: rtl/lvl_lane.sv
// Module lvl_lane
// Accumulates the sum and the sum of squares of one lane of signed samples.
// Assumes: SUM_W >= SAMP_W and SQ_W >= 2*SAMP_W; the totals wrap silently if
// the window is too long for the chosen widths. clr has priority over en.
module lvl_lane #(
    parameter int SAMP_W = 8,
    parameter int SUM_W  = 24,
    parameter int SQ_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [SAMP_W-1:0] sample,
    output logic [SUM_W-1:0]  sum_o,
    output logic [SQ_W-1:0]   sq_o
);

    localparam int PROD_W = 2 * SAMP_W;

    logic signed [PROD_W-1:0] prod;
    logic        [SUM_W-1:0]  samp_ext;
    logic        [SQ_W-1:0]   prod_ext;

    // Sign-extend the sample and form its (non-negative) square.
    always_comb begin
        prod     = $signed(sample) * $signed(sample);
        samp_ext = SUM_W'($signed(sample));
        prod_ext = SQ_W'($unsigned(prod));
    end

    // Running totals: cleared on clr, advanced on en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o <= '0;
            sq_o  <= '0;
        end else if (clr) begin
            sum_o <= '0;
            sq_o  <= '0;
        end else if (en) begin
            sum_o <= sum_o + samp_ext;
            sq_o  <= sq_o + prod_ext;
        end
    end

    // R7: a clear leaves both totals at zero on the next cycle.
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_o == '0 && sq_o == '0));

    // R5: the sum of squares never decreases while accumulating.
    a_r5_sq_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (sq_o >= $past(sq_o)));

    // R3: with neither clr nor en the totals hold.
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(sum_o) && $stable(sq_o)));

endmodule

// File: rtl/lvl_seq.sv
// Module lvl_seq
// Run sequencer: starts a run on ctrl_wr, counts 2^LOG2_WIN accepted samples,
// then raises a one-cycle commit and sets done.
// Assumes: ctrl_wr is a single-cycle strobe; a strobe always wins over a sample.
module lvl_seq
    import rms_acc_pkg::*;
#(
    parameter int LOG2_WIN = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  logic     samp_valid,
    output acc_ctl_t ctl,
    output logic     busy,
    output logic     done
);

    localparam logic [LOG2_WIN-1:0] LAST_IDX = '1;

    logic [LOG2_WIN-1:0] cnt;
    logic                commit_q;
    logic                take;
    logic                last;

    // Decide whether the current sample is accepted and whether it closes the run.
    always_comb begin
        take       = busy && samp_valid && !ctrl_wr;
        last       = take && (cnt == LAST_IDX);
        ctl.clr    = ctrl_wr;
        ctl.en     = take;
        ctl.commit = commit_q;
    end

    // Run state: busy, sample count, commit pulse and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            cnt      <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= last;
            if (ctrl_wr) begin
                busy <= 1'b1;
                done <= 1'b0;
                cnt  <= '0;
            end else begin
                if (take) begin
                    cnt <= cnt + 1'b1;
                end
                if (last) begin
                    busy <= 1'b0;
                end
                if (commit_q) begin
                    done <= 1'b1;
                end
            end
        end
    end

    // R2: a control write makes the block busy and clears done.
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (busy && !done));

    // R7: a control write restarts the sample count at zero.
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (cnt == '0));

    // R6: done is held until the next control write.
    a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ctrl_wr) |=> done);

    // R10: busy and done are never high together.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10: when busy falls without a restart, the commit follows on the next edge.
    a_r10_commit_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !ctrl_wr) |-> commit_q);

endmodule

// File: rtl/lvl_rmem.sv
// Module lvl_rmem
// Result memory: two words per lane (even = sum, odd = sum of squares),
// all loaded in one edge on commit, read through a registered port.
// Assumes: RES_W >= SUM_W and RES_W >= SQ_W; addresses past the last word read 0.
module lvl_rmem #(
    parameter int N_IN   = 8,
    parameter int SUM_W  = 24,
    parameter int SQ_W   = 32,
    parameter int RES_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [N_IN*SUM_W-1:0]  sum_flat,
    input  logic [N_IN*SQ_W-1:0]   sq_flat,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [RES_W-1:0]       rd_data
);

    localparam int WORDS = 2 * N_IN;

    logic [RES_W-1:0] mem [WORDS];

    // Load every word at once when a run commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < N_IN; i++) begin
                mem[2*i]   <= RES_W'(sum_flat[i*SUM_W +: SUM_W]);
                mem[2*i+1] <= RES_W'(sq_flat[i*SQ_W +: SQ_W]);
            end
        end
    end

    // Registered read port with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (int'(rd_addr) < WORDS) begin
            rd_data <= mem[rd_addr];
        end else begin
            rd_data <= '0;
        end
    end

    // R6: without a commit no result word changes.
    for (genvar g = 0; g < WORDS; g++) begin : g_hold
        a_r6_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> $stable(mem[g]));
    end

endmodule

// File: rtl/rms_power_accum.sv
// Module rms_power_accum
// Top level: per-lane sum and sum-of-squares over a 2^LOG2_WIN sample window,
// armed by a control write and published to a word-addressed result memory.
// Assumes: samp_data packs lane i at bits [i*SAMP_W +: SAMP_W].
module rms_power_accum
    import rms_acc_pkg::*;
#(
    parameter  int N_IN     = 8,
    parameter  int SAMP_W   = 8,
    parameter  int LOG2_WIN = 16,
    parameter  int SUM_W    = 24,
    parameter  int SQ_W     = 32,
    localparam int RES_W    = (SUM_W > SQ_W) ? SUM_W : SQ_W,
    localparam int ADDR_W   = $clog2(2 * N_IN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_wr,
    input  logic                     samp_valid,
    input  logic [N_IN*SAMP_W-1:0]   samp_data,
    output logic                     busy,
    output logic                     done,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [RES_W-1:0]         rd_data
);

    acc_ctl_t                ctl;
    logic [N_IN*SUM_W-1:0]   sum_flat;
    logic [N_IN*SQ_W-1:0]    sq_flat;

    lvl_seq #(
        .LOG2_WIN (LOG2_WIN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .samp_valid (samp_valid),
        .ctl        (ctl),
        .busy       (busy),
        .done       (done)
    );

    // One accumulator per input lane.
    for (genvar i = 0; i < N_IN; i++) begin : g_lane
        lvl_lane #(
            .SAMP_W (SAMP_W),
            .SUM_W  (SUM_W),
            .SQ_W   (SQ_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (ctl.clr),
            .en     (ctl.en),
            .sample (samp_data[i*SAMP_W +: SAMP_W]),
            .sum_o  (sum_flat[i*SUM_W +: SUM_W]),
            .sq_o   (sq_flat[i*SQ_W +: SQ_W])
        );
    end

    lvl_rmem #(
        .N_IN   (N_IN),
        .SUM_W  (SUM_W),
        .SQ_W   (SQ_W),
        .RES_W  (RES_W),
        .ADDR_W (ADDR_W)
    ) u_rmem (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (ctl.commit),
        .sum_flat (sum_flat),
        .sq_flat  (sq_flat),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/rms_power_accum_bench.sv
// Scoreboard bench: the driver computes expected words per run and queues
// them; the result reader pops and compares against the read port.
module rms_power_accum_bench;

    localparam int N_IN     = 8;
    localparam int SAMP_W   = 8;
    localparam int LOG2_WIN = 4;
    localparam int SUM_W    = 24;
    localparam int SQ_W     = 32;
    localparam int WIN      = 1 << LOG2_WIN;
    localparam int WORDS    = 2 * N_IN;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   ctrl_wr = 1'b0;
    logic                   samp_valid = 1'b0;
    logic [N_IN*SAMP_W-1:0] samp_data = '0;
    logic                   busy;
    logic                   done;
    logic [3:0]             rd_addr = '0;
    logic [31:0]            rd_data;

    int          n_chk = 0;
    int          n_bad = 0;
    longint      e_sum [N_IN];
    longint      e_sq  [N_IN];
    int          pat_idx = 0;
    logic [31:0] exp_q [$];
    logic [31:0] last_run [WORDS];

    always #4 clk = ~clk;   // 125 MHz

    rms_power_accum #(
        .N_IN     (N_IN),
        .SAMP_W   (SAMP_W),
        .LOG2_WIN (LOG2_WIN),
        .SUM_W    (SUM_W),
        .SQ_W     (SQ_W)
    ) u_rms_power_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .samp_valid (samp_valid),
        .samp_data  (samp_data),
        .busy       (busy),
        .done       (done),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample generator: mode 0 is a moving pattern, mode 1 fixed extreme codes per lane.
    function automatic logic [7:0] gen(input int mode, input int seed, input int lane, input int k);
        logic [7:0] tbl [8];
        tbl = '{8'h80, 8'h7F, 8'h00, 8'hFF, 8'h01, 8'h40, 8'hC0, 8'h64};
        if (mode == 1) return tbl[lane];
        return 8'(k * (lane * 2 + 3) + seed * 17 + lane * 29);
    endfunction

    task automatic start_run();
        @(negedge clk);
        ctrl_wr = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            e_sum[i] = 0;
            e_sq[i]  = 0;
        end
        @(negedge clk);
        ctrl_wr = 1'b0;
        chk("R2 busy after write", {31'b0, busy}, 32'd1);
        chk("R2 done cleared", {31'b0, done}, 32'd0);
    endtask

    // Driver: feeds n accepted samples, optionally with invalid gap cycles.
    task automatic feed(input int mode, input int seed, input int n, input bit gaps);
        int k = 0;
        int c = 0;
        while (k < n) begin
            @(negedge clk);
            if (gaps && (c % 3 == 2)) begin
                samp_valid = 1'b0;
                samp_data  = {N_IN{8'h5A}};
            end else begin
                samp_valid = 1'b1;
                for (int i = 0; i < N_IN; i++) begin
                    logic signed [7:0] s;
                    s = gen(mode, seed, i, pat_idx);
                    samp_data[i*SAMP_W +: SAMP_W] = s;
                    e_sum[i] += longint'(s);
                    e_sq[i]  += longint'(s) * longint'(s);
                end
                pat_idx++;
                k++;
            end
            c++;
        end
        @(negedge clk);
        samp_valid = 1'b0;
        samp_data  = '0;
    endtask

    task automatic push_run();
        for (int i = 0; i < N_IN; i++) begin
            last_run[2*i]   = {8'h00, 24'(e_sum[i])};
            last_run[2*i+1] = 32'(e_sq[i]);
        end
        for (int w = 0; w < WORDS; w++) exp_q.push_back(last_run[w]);
    endtask

    task automatic push_last();
        for (int w = 0; w < WORDS; w++) exp_q.push_back(last_run[w]);
    endtask

    // Monitor: reads every word and pops the matching expectation.
    task automatic drain(input string tag);
        for (int w = 0; w < WORDS; w++) begin
            logic [31:0] e;
            @(negedge clk);
            rd_addr = 4'(w);
            @(negedge clk);
            e = exp_q.pop_front();
            if (w % 2 == 0) chk({tag, " R4 sum word"}, rd_data, e);
            else            chk({tag, " R5 square word"}, rd_data, e);
        end
    endtask

    // R10 timing: called on the negedge right after the final sample edge.
    task automatic finish_timing(input string tag);
        chk({tag, " R10 busy low after last"}, {31'b0, busy}, 32'd0);
        chk({tag, " R10 done not yet"}, {31'b0, done}, 32'd0);
        @(negedge clk);
        chk({tag, " R10 done one edge later"}, {31'b0, done}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        for (int w = 0; w < WORDS; w++) exp_q.push_back(32'd0);
        drain("R1 reset");

        // R3: samples before any control write are ignored
        feed(0, 9, 5, 1'b0);
        chk("R3 no run without write", {31'b0, busy}, 32'd0);
        for (int w = 0; w < WORDS; w++) exp_q.push_back(32'd0);
        drain("R3 idle");

        // Run A: moving pattern with gaps; R3 count, R9 per-lane independence
        start_run();
        feed(0, 1, WIN - 1, 1'b1);
        chk("R3 still busy before last", {31'b0, busy}, 32'd1);
        feed(0, 1, 1, 1'b0);
        finish_timing("A");
        push_run();
        drain("A R9");

        // R6 / R3: done holds, and samples while idle change nothing
        repeat (10) @(negedge clk);
        chk("R6 done held", {31'b0, done}, 32'd1);
        feed(1, 0, 6, 1'b0);
        chk("R6 done held after idle samples", {31'b0, done}, 32'd1);
        push_last();
        drain("R3 idle after run");

        // Run B: extreme codes held a full window (sign at bit 23)
        start_run();
        feed(1, 0, WIN, 1'b0);
        finish_timing("B");
        push_run();
        drain("B");
        chk("R4 all -128 sum", last_run[0], 32'h00FF_F800);
        chk("R5 all -128 squares", last_run[1], 32'd262144);

        // R8: registered read latency
        @(negedge clk);
        rd_addr = 4'd1;
        @(negedge clk);
        chk("R8 word 1 after one edge", rd_data, last_run[1]);
        rd_addr = 4'd2;
        #1;
        chk("R8 no change before edge", rd_data, last_run[1]);
        @(negedge clk);
        chk("R8 word 2 after edge", rd_data, last_run[2]);

        // Run C: old results during a run, then restart mid-run (R6, R7)
        start_run();
        feed(0, 4, 5, 1'b0);
        push_last();
        drain("R6 old results during run");
        @(negedge clk);
        ctrl_wr    = 1'b1;
        samp_valid = 1'b1;
        samp_data  = {N_IN{8'h7F}};
        for (int i = 0; i < N_IN; i++) begin
            e_sum[i] = 0;
            e_sq[i]  = 0;
        end
        @(negedge clk);
        ctrl_wr    = 1'b0;
        samp_valid = 1'b0;
        chk("R7 busy after restart", {31'b0, busy}, 32'd1);
        feed(0, 6, WIN - 1, 1'b1);
        chk("R7 restart counts from zero", {31'b0, busy}, 32'd1);
        feed(0, 6, 1, 1'b0);
        finish_timing("C");
        push_run();
        drain("C R7");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule